// File: doc/BRIEF.md
# Pipelined Signed Carry-Save Array Multiplier

This block multiplies two K-bit two's-complement operands and returns the full 2K-bit signed product. It is built from a grid of identical cells. Each cell forms one partial-product bit with an AND gate and adds it, with a full adder, into a running sum and carry. Sign handling needs no sign extension. Each partial-product bit that pairs the top bit of one operand with a lower bit of the other enters the array inverted. The bit formed from both top bits enters as it is. Two constant ones are added, one in column K and one in column 2K-1. The final carry-propagate row is a ripple adder, and its most significant bit carries negative weight.

The array can register the sum and carry vectors after every row. A valid bit travels through the pipeline beside the data. The operands move along with the rows, and the multiplier operand shifts down one bit per row, so every row works on bits from the same sample. The block accepts a new operand pair on every clock. The output register always holds the product of the sample launched LAT cycles earlier, where LAT is K+1 when rows are registered and 1 when they are not.

Top module: `smul_bw_array`

## Requirements
- R1: When out_valid is high, out_p equals the signed product of the in_a and in_x sampled with in_valid high LAT cycles earlier, read as a 2K-bit two's-complement number.
- R2: With REG_ROWS=1, a single in_valid pulse gives exactly one out_valid pulse, K+1 rising edges later. With REG_ROWS=0 the pulse comes one edge later.
- R3: While rst_n is low, out_valid and out_p are 0. A sample in flight when reset is asserted never produces out_valid.
- R4: A new operand pair may be presented on every clock. Results leave in issue order with one result per cycle.
- R5: If either operand is zero, the product is zero.
- R6: The most negative operand times itself gives +2^(2K-2), with out_p[2K-1]=0. For K=5 this is 10'h100.
- R7: out_p[2K-1] is 1 exactly when both operands are nonzero and their sign bits differ.
- R8: A cycle with in_valid low produces a cycle with out_valid low, LAT cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_a and in_x this cycle |
| in_a | input | K | Multiplicand, two's complement |
| in_x | input | K | Multiplier, two's complement |
| out_valid | output | 1 | out_p holds a valid product |
| out_p | output | 2K | Signed product |

## Verification
The bound checks assume three things about the inputs. The operands carry no unknown bits on any rising edge. Reset is asserted from time zero. in_valid is 0 or 1 on every edge, so the checker's reference pipeline and the array see the same samples. The bench changes its inputs only on falling edges, holds reset low before its first sample, and drives in_valid as a plain 0 or 1. It sends all 1024 operand pairs back to back, with some in_valid gaps, and also a short table of sign and extreme-value cases.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // Cycles from an accepted sample to its out_valid.
    function automatic int unsigned smul_latency(int unsigned k, bit reg_rows);
        return reg_rows ? k + 1 : 1;
    endfunction

    // A partial-product bit is inverted when exactly one of its two
    // operand indices is the sign position.
    function automatic bit smul_flip(int unsigned row, int unsigned col_op, int unsigned k);
        return (row == k - 1) != (col_op == k - 1);
    endfunction

endpackage

// File: rtl/smul_fa.sv
module smul_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/smul_csa_row.sv
module smul_csa_row #(
    parameter int K   = 5,
    parameter int ROW = 0
) (
    input  logic [2*K-1:0] s_in,
    input  logic [2*K-1:0] c_in,
    input  logic [K-1:0]   a,
    input  logic           xb,
    output logic [2*K-1:0] s_out,
    output logic [2*K-1:0] c_out
);
    localparam int W = 2 * K;

    assign c_out[0] = 1'b0;

    for (genvar c = 0; c < W; c++) begin : g_col
        logic pp;
        if (c >= ROW && c < ROW + K) begin : g_pp
            localparam int J = c - ROW;
            localparam bit FLIP = smul_pkg::smul_flip(ROW, J, K);
            assign pp = (a[J] & xb) ^ FLIP;
        end else begin : g_nopp
            assign pp = 1'b0;
        end

        if (c == W - 1) begin : g_top
            // Carry out of the top column has weight 2^W and is dropped.
            assign s_out[c] = s_in[c] ^ c_in[c] ^ pp;
        end else begin : g_cell
            smul_fa u_fa (
                .a (s_in[c]),
                .b (c_in[c]),
                .ci(pp),
                .s (s_out[c]),
                .co(c_out[c+1])
            );
        end
    end
endmodule

// File: rtl/smul_ripple.sv
module smul_ripple #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_msb
            assign sum[i] = a[i] ^ b[i] ^ cy[i];
        end else begin : g_fa
            smul_fa u_fa (
                .a (a[i]),
                .b (b[i]),
                .ci(cy[i]),
                .s (sum[i]),
                .co(cy[i+1])
            );
        end
    end
endmodule

// File: rtl/smul_bw_array.sv
module smul_bw_array #(
    parameter int K        = 5,
    parameter bit REG_ROWS = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [K-1:0]   in_a,
    input  logic [K-1:0]   in_x,
    output logic           out_valid,
    output logic [2*K-1:0] out_p
);
    localparam int W = 2 * K;
    localparam logic [W-1:0] INJ = (W'(1) << K) | (W'(1) << (W - 1));

    // Stage r holds what row r consumes; stage K feeds the ripple adder.
    logic [W-1:0] st_s [K+1];
    logic [W-1:0] st_c [K+1];
    logic         st_v [K+1];
    logic [K-1:0] st_a [K];
    logic [K-1:0] st_x [K];

    assign st_s[0] = '0;
    assign st_c[0] = INJ;
    assign st_v[0] = in_valid;
    assign st_a[0] = in_a;
    assign st_x[0] = in_x;

    for (genvar r = 0; r < K; r++) begin : g_row
        logic [W-1:0] row_s;
        logic [W-1:0] row_c;

        smul_csa_row #(
            .K  (K),
            .ROW(r)
        ) u_row (
            .s_in (st_s[r]),
            .c_in (st_c[r]),
            .a    (st_a[r]),
            .xb   (st_x[r][0]),
            .s_out(row_s),
            .c_out(row_c)
        );

        if (REG_ROWS) begin : g_reg
            logic [W-1:0] q_s;
            logic [W-1:0] q_c;
            logic         q_v;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_s <= '0;
                    q_c <= '0;
                    q_v <= 1'b0;
                end else begin
                    q_s <= row_s;
                    q_c <= row_c;
                    q_v <= st_v[r];
                end
            end

            assign st_s[r+1] = q_s;
            assign st_c[r+1] = q_c;
            assign st_v[r+1] = q_v;

            if (r < K - 1) begin : g_skew
                logic [K-1:0] q_a;
                logic [K-1:0] q_x;

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        q_a <= '0;
                        q_x <= '0;
                    end else begin
                        q_a <= st_a[r];
                        q_x <= {1'b0, st_x[r][K-1:1]};
                    end
                end

                assign st_a[r+1] = q_a;
                assign st_x[r+1] = q_x;
            end
        end else begin : g_comb
            assign st_s[r+1] = row_s;
            assign st_c[r+1] = row_c;
            assign st_v[r+1] = st_v[r];
            if (r < K - 1) begin : g_pass
                assign st_a[r+1] = st_a[r];
                assign st_x[r+1] = {1'b0, st_x[r][K-1:1]};
            end
        end
    end

    logic [W-1:0] cpa_sum;

    smul_ripple #(
        .W(W)
    ) u_cpa (
        .a  (st_s[K]),
        .b  (st_c[K]),
        .sum(cpa_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_p     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_p     <= cpa_sum;
            out_valid <= st_v[K];
        end
    end
endmodule

// File: rtl/smul_bw_check.sv
module smul_bw_check #(
    parameter int K        = 5,
    parameter bit REG_ROWS = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [K-1:0]   in_a,
    input logic [K-1:0]   in_x,
    input logic           out_valid,
    input logic [2*K-1:0] out_p
);
    localparam int W   = 2 * K;
    localparam int LAT = smul_pkg::smul_latency(K, REG_ROWS);
    localparam logic [K-1:0] MINV = {1'b1, {(K-1){1'b0}}};

    logic signed [W-1:0] prod;
    assign prod = $signed(in_a) * $signed(in_x);

    logic [W-1:0] rp [LAT];
    logic [LAT-1:0] rv, rz, rm, rn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rv <= '0;
            rz <= '0;
            rm <= '0;
            rn <= '0;
            for (int i = 0; i < LAT; i++) rp[i] <= '0;
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin
                rp[i] <= rp[i-1];
                rv[i] <= rv[i-1];
                rz[i] <= rz[i-1];
                rm[i] <= rm[i-1];
                rn[i] <= rn[i-1];
            end
            rp[0] <= prod;
            rv[0] <= in_valid;
            rz[0] <= (in_a == '0) || (in_x == '0);
            rm[0] <= (in_a == MINV) && (in_x == MINV);
            rn[0] <= in_a[K-1] ^ in_x[K-1];
        end
    end

    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_p == rp[LAT-1]);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == rv[LAT-1]);

    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rz[LAT-1]) |-> out_p == '0);

    p_min_square_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rm[LAT-1]) |-> out_p == (W'(1) << (W - 2)));

    p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !rz[LAT-1]) |-> out_p[W-1] == rn[LAT-1]);

    p_reset_r3: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_p == '0));
endmodule

bind smul_bw_array smul_bw_check #(.K(K), .REG_ROWS(REG_ROWS)) u_chk (.*);

// File: tb/smul_bw_array_test.sv
`timescale 1ns/1ps
module smul_bw_array_test;
    localparam int K   = 5;
    localparam int W   = 2 * K;
    localparam int LAT = smul_pkg::smul_latency(K, 1'b1);
    localparam int NV  = 12;

    // {a, x, expected product}
    localparam logic [2*K+W-1:0] VEC [NV] = '{
        {5'b00000, 5'b00000, 10'h000},
        {5'b00001, 5'b00001, 10'h001},
        {5'b10000, 5'b10000, 10'h100},
        {5'b10000, 5'b01111, 10'h310},
        {5'b01111, 5'b01111, 10'h0E1},
        {5'b11111, 5'b11111, 10'h001},
        {5'b11111, 5'b01111, 10'h3F1},
        {5'b00111, 5'b11101, 10'h3EB},
        {5'b10000, 5'b00001, 10'h3F0},
        {5'b00000, 5'b10000, 10'h000},
        {5'b10000, 5'b11111, 10'h010},
        {5'b00101, 5'b00110, 10'h01E}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [K-1:0]   in_a = '0;
    logic [K-1:0]   in_x = '0;
    logic           out_valid;
    logic [W-1:0]   out_p;

    int checks = 0;
    int fails  = 0;
    bit mon_en = 1'b0;

    always #10 clk = ~clk;

    smul_bw_array #(.K(K), .REG_ROWS(1'b1)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_a     (in_a),
        .in_x     (in_x),
        .out_valid(out_valid),
        .out_p    (out_p)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected stream built from R1/R2/R8: a product and a valid per sample, LAT cycles deep.
    logic [W-1:0] ep [LAT];
    logic         ev [LAT];
    logic signed [W-1:0] bprod;
    assign bprod = $signed(in_a) * $signed(in_x);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                ep[i] <= '0;
                ev[i] <= 1'b0;
            end
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin
                ep[i] <= ep[i-1];
                ev[i] <= ev[i-1];
            end
            ep[0] <= bprod;
            ev[0] <= in_valid;
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            chk(out_valid == ev[LAT-1], "R8 R2 valid", W'(out_valid), W'(ev[LAT-1]));
            if (ev[LAT-1])
                chk(out_p == ep[LAT-1], "R4 R1 stream", out_p, ep[LAT-1]);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R3: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R3 valid in reset", W'(out_valid), '0);
        chk(out_p == '0, "R3 product in reset", out_p, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed table: R1, R2, R5, R6, R7
        for (int n = 0; n < NV; n++) begin
            logic [K-1:0] va, vx;
            logic [W-1:0] vp;
            {va, vx, vp} = VEC[n];
            in_a = va;
            in_x = vx;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (LAT - 2) @(negedge clk);
            chk(out_valid == 1'b0, "R2 early", W'(out_valid), '0);
            @(negedge clk);
            chk(out_valid == 1'b1, "R2 on time", W'(out_valid), W'(1));
            chk(out_p == vp, "R1 table", out_p, vp);
            if (va == '0 || vx == '0)
                chk(out_p == '0, "R5 zero operand", out_p, '0);
            else
                chk(out_p[W-1] == (va[K-1] ^ vx[K-1]), "R7 sign", W'(out_p[W-1]), W'(va[K-1] ^ vx[K-1]));
            if (va == 5'b10000 && vx == 5'b10000)
                chk(out_p == 10'h100, "R6 min squared", out_p, 10'h100);
            @(negedge clk);
            chk(out_valid == 1'b0, "R2 single pulse", W'(out_valid), '0);
        end

        // Exhaustive stream with gaps: R4, R8, R1 via monitor
        mon_en = 1'b1;
        for (int ia = 0; ia < (1 << K); ia++) begin
            for (int ix = 0; ix < (1 << K); ix++) begin
                in_a = K'(ia);
                in_x = K'(ix);
                in_valid = ((ia + ix) % 7) != 3;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        mon_en = 1'b0;

        // R3: a sample in flight is flushed by reset
        in_a = 5'b00011;
        in_x = 5'b00101;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_p == '0, "R3 mid reset", out_p, '0);
        rst_n = 1'b1;
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R3 flushed", W'(out_valid), '0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule